// File: doc/BRIEF.md
# Segmentation Offload DMA Request Generator

This block takes one large transmit segment, described by a header location, a header size, a payload location, a payload size and a maximum wire packet size, and expands it into a stream of DMA read requests. Each wire packet costs two requests. The first fetches the protocol header from host memory and the second fetches the next contiguous slice of payload. The NIC keeps no copy of the header, so every packet reads it again from host memory. Header rewriting and the DMA engine are handled elsewhere.

Every request carries sideband metadata: whether it is the header fetch, the byte offset of the packet's payload within the segment, a flag on both requests of the final packet, and a flag on the very last request of the segment. Requests leave over a valid/ready handshake. A descriptor is taken only when the generator is idle.

Top module: `tso_dma_reqgen`

## Requirements
- R1: After reset, `req_valid_o` is 0 and `desc_ready_o` is 1.
- R2: `desc_ready_o` is 0 from the cycle after a descriptor is accepted until the final request of that segment completes its handshake. It is 1 again in the next cycle. A `desc_valid_i` raised while busy has no effect on the requests in flight.
- R3: Each packet starts with a header request: `req_is_hdr_o`=1, address equal to the header address, length equal to the header length. When the payload is non-zero, a payload request (`req_is_hdr_o`=0) follows it.
- R4: The payload capacity per packet is the effective MTU minus the header length. Each payload request carries min(remaining, capacity) bytes at payload address plus `pkt_offset_o`. `pkt_offset_o` starts at 0 and grows by each slice, and it is the same on both requests of a packet.
- R5: A descriptor MTU field of 0 selects the default MTU of 1500 bytes. Any other value is used as given.
- R6: A descriptor with zero payload length produces exactly one request, a header request with `pkt_last_o`=1 and `req_last_o`=1.
- R7: While `req_valid_o`=1 and `req_ready_i`=0, the request stays valid and its address, length, header flag and last flag hold steady into the next cycle.
- R8: `pkt_last_o` is 1 on both requests of the final packet and 0 on the others. `req_last_o` is 1 only on the final request of the segment.
- R9: Payload lengths up to 65536 bytes are accepted and fully covered without gaps or overlap.
- R10: If the payload is an exact multiple of the capacity, the last packet is a full slice and no empty packet follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| desc_valid_i | input | 1 | Descriptor offered |
| desc_ready_o | output | 1 | Generator idle, descriptor taken |
| desc_hdr_addr_i | input | ADDR_W | Host address of header |
| desc_hdr_len_i | input | HLEN_W | Header bytes |
| desc_pay_addr_i | input | ADDR_W | Host address of payload |
| desc_pay_len_i | input | LEN_W | Payload bytes (0..65536) |
| desc_mtu_i | input | MTU_W | Max wire packet bytes, 0 selects default |
| req_valid_o | output | 1 | DMA read request valid |
| req_ready_i | input | 1 | DMA engine accepts request |
| req_addr_o | output | ADDR_W | Read address |
| req_len_o | output | MTU_W | Read length |
| req_is_hdr_o | output | 1 | Request is a header fetch |
| pkt_offset_o | output | LEN_W | Payload offset of current packet |
| pkt_last_o | output | 1 | Request belongs to final packet |
| req_last_o | output | 1 | Final request of the segment |

## Verification
The bench aims at the slice arithmetic at its edges: a zero-length payload, a payload that ends exactly on a capacity boundary, a one-byte tail, and a 64 KB segment. A wrong last-packet test would show up as an extra empty payload request or a dropped tail, and a wrong offset update would show up as overlapping or gapped payload addresses. Random back-pressure on `req_ready_i` exposes any request that changes while stalled. A descriptor held asserted during a busy segment exposes a generator that reloads in mid-segment. An MTU field of zero checks the default-capacity path.

// File: rtl/tso_pkg.sv
package tso_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HDR  = 2'd1,
    ST_PAY  = 2'd2
  } tso_state_e;
endpackage

// File: rtl/tso_desc_latch.sv
module tso_desc_latch #(
  parameter int unsigned ADDR_W      = 40,
  parameter int unsigned HLEN_W      = 8,
  parameter int unsigned LEN_W       = 17,
  parameter int unsigned MTU_W       = 14,
  parameter int unsigned DEFAULT_MTU = 1500
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] hdr_addr_i,
  input  logic [HLEN_W-1:0] hdr_len_i,
  input  logic [ADDR_W-1:0] pay_addr_i,
  input  logic [LEN_W-1:0]  pay_len_i,
  input  logic [MTU_W-1:0]  mtu_i,
  output logic [ADDR_W-1:0] hdr_addr_o,
  output logic [HLEN_W-1:0] hdr_len_o,
  output logic [ADDR_W-1:0] pay_addr_o,
  output logic [MTU_W-1:0]  cap_o,
  output logic              pay_zero_o
);
  localparam logic [MTU_W-1:0] MTU_DEF = MTU_W'(DEFAULT_MTU);

  logic [MTU_W-1:0] mtu_eff;
  assign mtu_eff = (mtu_i == '0) ? MTU_DEF : mtu_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hdr_addr_o <= '0;
      hdr_len_o  <= '0;
      pay_addr_o <= '0;
      cap_o      <= '0;
      pay_zero_o <= 1'b1;
    end else if (load_i) begin
      hdr_addr_o <= hdr_addr_i;
      hdr_len_o  <= hdr_len_i;
      pay_addr_o <= pay_addr_i;
      cap_o      <= mtu_eff - MTU_W'(hdr_len_i);
      pay_zero_o <= (pay_len_i == '0);
    end
  end
endmodule

// File: rtl/tso_cursor.sv
module tso_cursor #(
  parameter int unsigned LEN_W = 17
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             step_i,
  input  logic [LEN_W-1:0] step_len_i,
  output logic [LEN_W-1:0] off_o,
  output logic [LEN_W-1:0] rem_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      off_o <= '0;
      rem_o <= '0;
    end else if (load_i) begin
      off_o <= '0;
      rem_o <= len_i;
    end else if (step_i) begin
      off_o <= off_o + step_len_i;
      rem_o <= rem_o - step_len_i;
    end
  end
endmodule

// File: rtl/tso_slice_calc.sv
module tso_slice_calc #(
  parameter int unsigned LEN_W = 17,
  parameter int unsigned MTU_W = 14
) (
  input  logic [LEN_W-1:0] rem_i,
  input  logic [MTU_W-1:0] cap_i,
  output logic [MTU_W-1:0] slice_o,
  output logic             last_o
);
  logic [LEN_W-1:0] cap_ext;
  assign cap_ext = LEN_W'(cap_i);
  assign last_o  = (rem_i <= cap_ext);
  // remainder fits MTU_W whenever it is the final slice
  assign slice_o = last_o ? rem_i[MTU_W-1:0] : cap_i;
endmodule

// File: rtl/tso_dma_reqgen.sv
module tso_dma_reqgen #(
  parameter int unsigned ADDR_W      = 40,
  parameter int unsigned HLEN_W      = 8,
  parameter int unsigned LEN_W       = 17,
  parameter int unsigned MTU_W       = 14,
  parameter int unsigned DEFAULT_MTU = 1500
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              desc_valid_i,
  output logic              desc_ready_o,
  input  logic [ADDR_W-1:0] desc_hdr_addr_i,
  input  logic [HLEN_W-1:0] desc_hdr_len_i,
  input  logic [ADDR_W-1:0] desc_pay_addr_i,
  input  logic [LEN_W-1:0]  desc_pay_len_i,
  input  logic [MTU_W-1:0]  desc_mtu_i,
  output logic              req_valid_o,
  input  logic              req_ready_i,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic [MTU_W-1:0]  req_len_o,
  output logic              req_is_hdr_o,
  output logic [LEN_W-1:0]  pkt_offset_o,
  output logic              pkt_last_o,
  output logic              req_last_o
);
  import tso_pkg::*;

  tso_state_e state_q, state_d;

  logic              load, hs, step;
  logic [ADDR_W-1:0] hdr_addr, pay_addr;
  logic [HLEN_W-1:0] hdr_len;
  logic [MTU_W-1:0]  cap, slice;
  logic              pay_zero, slice_last;
  logic [LEN_W-1:0]  off, rem;

  assign desc_ready_o = (state_q == ST_IDLE);
  assign load         = desc_valid_i && desc_ready_o;
  assign req_valid_o  = (state_q != ST_IDLE);
  assign hs           = req_valid_o && req_ready_i;
  assign step         = hs && (state_q == ST_PAY);

  tso_desc_latch #(
    .ADDR_W(ADDR_W), .HLEN_W(HLEN_W), .LEN_W(LEN_W),
    .MTU_W(MTU_W), .DEFAULT_MTU(DEFAULT_MTU)
  ) u_desc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .hdr_addr_i (desc_hdr_addr_i),
    .hdr_len_i  (desc_hdr_len_i),
    .pay_addr_i (desc_pay_addr_i),
    .pay_len_i  (desc_pay_len_i),
    .mtu_i      (desc_mtu_i),
    .hdr_addr_o (hdr_addr),
    .hdr_len_o  (hdr_len),
    .pay_addr_o (pay_addr),
    .cap_o      (cap),
    .pay_zero_o (pay_zero)
  );

  tso_cursor #(.LEN_W(LEN_W)) u_cursor (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .len_i      (desc_pay_len_i),
    .step_i     (step),
    .step_len_i (LEN_W'(slice)),
    .off_o      (off),
    .rem_o      (rem)
  );

  tso_slice_calc #(.LEN_W(LEN_W), .MTU_W(MTU_W)) u_slice (
    .rem_i   (rem),
    .cap_i   (cap),
    .slice_o (slice),
    .last_o  (slice_last)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (load) state_d = ST_HDR;
      ST_HDR:  if (hs)   state_d = pay_zero ? ST_IDLE : ST_PAY;
      ST_PAY:  if (hs)   state_d = slice_last ? ST_IDLE : ST_HDR;
      default:           state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign req_is_hdr_o = (state_q == ST_HDR);
  assign req_addr_o   = req_is_hdr_o ? hdr_addr : (pay_addr + ADDR_W'(off));
  assign req_len_o    = req_is_hdr_o ? MTU_W'(hdr_len) : slice;
  assign pkt_offset_o = off;
  assign pkt_last_o   = req_valid_o && slice_last;
  assign req_last_o   = (state_q == ST_PAY && slice_last) ||
                        (state_q == ST_HDR && pay_zero);
endmodule

// File: rtl/tso_dma_reqgen_chk.sv
module tso_dma_reqgen_chk #(
  parameter int unsigned ADDR_W      = 40,
  parameter int unsigned HLEN_W      = 8,
  parameter int unsigned LEN_W       = 17,
  parameter int unsigned MTU_W       = 14,
  parameter int unsigned DEFAULT_MTU = 1500
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              desc_valid_i,
  input logic              desc_ready_o,
  input logic [HLEN_W-1:0] desc_hdr_len_i,
  input logic [MTU_W-1:0]  desc_mtu_i,
  input logic              req_valid_o,
  input logic              req_ready_i,
  input logic [ADDR_W-1:0] req_addr_o,
  input logic [MTU_W-1:0]  req_len_o,
  input logic              req_is_hdr_o,
  input logic              pkt_last_o,
  input logic              req_last_o
);
  logic              hdr_seen;
  logic [MTU_W-1:0]  lat_mtu;
  logic [HLEN_W-1:0] lat_hlen;
  logic [MTU_W:0]    pkt_sum;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hdr_seen <= 1'b0;
      lat_mtu  <= MTU_W'(DEFAULT_MTU);
      lat_hlen <= '0;
    end else begin
      if (desc_valid_i && desc_ready_o) begin
        lat_mtu  <= (desc_mtu_i == '0) ? MTU_W'(DEFAULT_MTU) : desc_mtu_i;
        lat_hlen <= desc_hdr_len_i;
      end
      if (req_valid_o && req_ready_i)
        hdr_seen <= req_is_hdr_o && !req_last_o;
    end
  end

  assign pkt_sum = (MTU_W+1)'(req_len_o) + (MTU_W+1)'(lat_hlen);

  assert_stall_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && !req_ready_i |=> req_valid_o && $stable(req_addr_o) &&
      $stable(req_len_o) && $stable(req_is_hdr_o) && $stable(req_last_o));

  assert_busy_block_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> !desc_ready_o);

  assert_hdr_before_pay_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && !req_is_hdr_o |-> hdr_seen);

  assert_no_double_hdr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && req_is_hdr_o |-> !hdr_seen);

  assert_fit_mtu_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && !req_is_hdr_o |-> pkt_sum <= (MTU_W+1)'(lat_mtu));

  assert_last_in_last_pkt_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_last_o |-> pkt_last_o && req_valid_o);

  assert_no_empty_slice_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && !req_is_hdr_o |-> req_len_o != '0);
endmodule

bind tso_dma_reqgen tso_dma_reqgen_chk #(
  .ADDR_W(ADDR_W), .HLEN_W(HLEN_W), .LEN_W(LEN_W),
  .MTU_W(MTU_W), .DEFAULT_MTU(DEFAULT_MTU)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .desc_valid_i   (desc_valid_i),
  .desc_ready_o   (desc_ready_o),
  .desc_hdr_len_i (desc_hdr_len_i),
  .desc_mtu_i     (desc_mtu_i),
  .req_valid_o    (req_valid_o),
  .req_ready_i    (req_ready_i),
  .req_addr_o     (req_addr_o),
  .req_len_o      (req_len_o),
  .req_is_hdr_o   (req_is_hdr_o),
  .pkt_last_o     (pkt_last_o),
  .req_last_o     (req_last_o)
);

// File: tb/tso_dma_reqgen_bench.sv
`timescale 1ns/1ps
module tso_dma_reqgen_bench;
  localparam int ADDR_W = 40;
  localparam int HLEN_W = 8;
  localparam int LEN_W  = 17;
  localparam int MTU_W  = 14;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              desc_valid = 1'b0;
  logic              desc_ready;
  logic [ADDR_W-1:0] d_hdr_addr = '0;
  logic [HLEN_W-1:0] d_hdr_len = '0;
  logic [ADDR_W-1:0] d_pay_addr = '0;
  logic [LEN_W-1:0]  d_pay_len = '0;
  logic [MTU_W-1:0]  d_mtu = '0;
  logic              req_valid;
  logic              req_ready = 1'b0;
  logic [ADDR_W-1:0] req_addr;
  logic [MTU_W-1:0]  req_len;
  logic              req_is_hdr;
  logic [LEN_W-1:0]  pkt_off;
  logic              pkt_last;
  logic              req_last;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  tso_dma_reqgen u_tso_dma_reqgen (
    .clk_i(clk), .rst_ni(rst_n),
    .desc_valid_i(desc_valid), .desc_ready_o(desc_ready),
    .desc_hdr_addr_i(d_hdr_addr), .desc_hdr_len_i(d_hdr_len),
    .desc_pay_addr_i(d_pay_addr), .desc_pay_len_i(d_pay_len),
    .desc_mtu_i(d_mtu),
    .req_valid_o(req_valid), .req_ready_i(req_ready),
    .req_addr_o(req_addr), .req_len_o(req_len), .req_is_hdr_o(req_is_hdr),
    .pkt_offset_o(pkt_off), .pkt_last_o(pkt_last), .req_last_o(req_last)
  );

  task automatic chk(bit ok, string tag, longint act, longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint cap_of(int hlen, int mtu);
    return ((mtu == 0) ? 1500 : mtu) - hlen;
  endfunction

  // count of requests expected for one segment
  function automatic int nreq_of(int hlen, int plen, int mtu);
    longint c = cap_of(hlen, mtu);
    if (plen == 0) return 1;
    return 2 * int'((plen + c - 1) / c);
  endfunction

  task automatic run_seg(longint ha, int hlen, longint pa, int plen, int mtu,
                         int stall_pct, bit noise);
    longint cap = cap_of(hlen, mtu);
    longint e_off = 0;
    longint e_rem = plen;
    bit     e_hdr = 1'b1;
    bit     fin = 1'b0;
    bit     p_stall = 1'b0;
    longint p_addr = 0, p_len = 0;
    bit     p_hdr = 1'b0;
    int     nreq = 0;
    int     guard = 0;
    @(negedge clk);
    chk(desc_ready == 1'b1, "R2 idle ready", desc_ready, 1);
    d_hdr_addr = ADDR_W'(ha); d_hdr_len = HLEN_W'(hlen);
    d_pay_addr = ADDR_W'(pa); d_pay_len = LEN_W'(plen); d_mtu = MTU_W'(mtu);
    desc_valid = 1'b1;
    @(negedge clk);
    desc_valid = noise;
    if (noise) begin
      d_hdr_addr = ~d_hdr_addr; d_pay_addr = ~d_pay_addr;
      d_pay_len = LEN_W'(7); d_mtu = MTU_W'(100); d_hdr_len = 8'd20;
    end
    while (!fin && guard < 100000) begin
      guard++;
      req_ready = ($urandom_range(99) >= stall_pct);
      chk(desc_ready == 1'b0, "R2 busy", desc_ready, 0);
      chk(req_valid == 1'b1, "R3 valid", req_valid, 1);
      if (p_stall)
        chk(req_addr == ADDR_W'(p_addr) && req_len == MTU_W'(p_len) && req_is_hdr == p_hdr,
            "R7 stall hold", req_addr, p_addr);
      p_stall = req_valid && !req_ready;
      p_addr = req_addr; p_len = req_len; p_hdr = req_is_hdr;
      if (req_valid && req_ready) begin
        longint sl = (e_rem <= cap) ? e_rem : cap;
        bit lp = (e_rem <= cap);
        nreq++;
        chk(req_is_hdr == e_hdr, "R3 hdr flag", req_is_hdr, e_hdr);
        chk(pkt_off == LEN_W'(e_off), "R4 offset", pkt_off, e_off);
        chk(pkt_last == lp, "R8 pkt_last", pkt_last, lp);
        if (e_hdr) begin
          chk(req_addr == ADDR_W'(ha), "R3 hdr addr", req_addr, ha);
          chk(req_len == MTU_W'(hlen), "R3 hdr len", req_len, hlen);
          chk(req_last == (plen == 0), "R6 hdr req_last", req_last, plen == 0);
          if (plen == 0) fin = 1'b1;
          else e_hdr = 1'b0;
        end else begin
          chk(req_addr == ADDR_W'(pa + e_off), "R4 pay addr", req_addr, pa + e_off);
          chk(req_len == MTU_W'(sl), "R4 pay len", req_len, sl);
          chk(req_last == lp, "R8 req_last", req_last, lp);
          e_off += sl; e_rem -= sl; e_hdr = 1'b1;
          if (lp) fin = 1'b1;
        end
        if (fin) desc_valid = 1'b0;
      end
      @(negedge clk);
    end
    req_ready = 1'b0;
    chk(fin, "R9 segment completes", fin, 1);
    chk(nreq == nreq_of(hlen, plen, mtu), "R10 request count", nreq, nreq_of(hlen, plen, mtu));
    chk(e_off == plen, "R9 bytes covered", e_off, plen);
    chk(desc_ready == 1'b1 && req_valid == 1'b0, "R2 ready after last", desc_ready, 1);
  endtask

  initial begin
    #(20 * 190000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    #45;
    @(negedge clk);
    chk(req_valid == 1'b0, "R1 reset valid", req_valid, 0);
    chk(desc_ready == 1'b1, "R1 reset ready", desc_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_valid == 1'b0, "R1 idle valid", req_valid, 0);

    // R5: default MTU, slices 1446,1446,108
    run_seg(40'h10_0000_0000, 54, 40'h20_0000_0000, 3000, 0, 0, 1'b0);
    // R6: header-only segment
    run_seg(40'h00_0000_1000, 42, 40'h00_0000_8000, 0, 0, 30, 1'b0);
    // R10: exact multiple of capacity (1000-100=900)
    run_seg(40'h00_0001_0000, 100, 40'h00_0002_0000, 2700, 1000, 20, 1'b0);
    // one-byte tail
    run_seg(40'h00_0003_0000, 60, 40'h00_0004_0000, 901, 960, 20, 1'b0);
    // R9: 64 KB with default MTU, R2 noise on descriptor while busy
    run_seg(40'h0A_0000_0000, 54, 40'h0B_0000_0000, 65536, 0, 40, 1'b1);
    // R5: explicit non-default MTU
    run_seg(40'h00_0005_0000, 54, 40'h00_0006_0000, 5000, 9000, 10, 1'b0);

    for (int i = 0; i < 30; i++) begin
      int hl = $urandom_range(128, 14);
      int mt = ($urandom_range(3) == 0) ? 0 : $urandom_range(9000, hl + 64);
      int sel = $urandom_range(7);
      int pl = (sel == 0) ? 0 : (sel == 1) ? 65536 : $urandom_range(65536, 1);
      longint ha = {$urandom(), $urandom()} & 40'hFF_FFFF_FFC0;
      longint pa = {$urandom(), $urandom()} & 40'h7F_FFFF_FFFF;
      run_seg(ha, hl, pa, pl, mt, $urandom_range(60), $urandom_range(1));
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule